// File: doc/BRIEF.md
# Disk DMA Staging Buffer with Packet Alarms

This block sits between a 16-bit disk-bus transfer engine and a 32-bit host DMA engine and holds data while a DMA transfer runs. Toward the drive it accepts halfwords from the engine or hands halfwords to it. It raises a combinational pause whenever one more halfword would overrun or underrun the store, so the engine waits and nothing is lost. Toward the host it exchanges longwords. Two halfwords form one longword, with the earlier halfword in the low half.

A registered receive alarm tells the host engine that at least one whole packet can be read. A registered transmit alarm tells it that room for a whole packet exists. The packet length is a loadable register. In PIO mode the store stays idle. A transfer step only happens when DMA mode is selected, the enable bit is set and the drive is requesting. Three reset-defined outputs give the bus state: the bus reset, the acknowledge and the data-drive enable. The ultra/multiword selection is handed on to the engine.

Top module: `ata_dma_fifo`

## Requirements
- R1: With `cfg_dma_mode`=0 (PIO), `bus_pause` is 1, host writes and reads are ignored and both alarms are 0 one cycle later.
- R2: A halfword moves on the bus side only when `cfg_dma_mode`, `cfg_dma_en` and `drv_dmarq` are all 1; otherwise `bus_pause` is 1. `bus_dmack_n` is registered and is 0 exactly in the cycle after those three were all 1.
- R3: `eng_udma_sel` equals `cfg_udma_sel` delayed by one clock (1 = ultra, 0 = multiword).
- R4: With `cfg_dir`=1 (drive-to-host), `bus_pause` is 1 while the store holds DEPTH (64) longwords, and no halfword is taken.
- R5: With `cfg_dir`=0 (host-to-drive), `bus_pause` is 1 while the store is empty.
- R6: `host_rx_alarm` is registered. It is 1 in the cycle after a cycle in which DMA mode was set, `cfg_dir`=1 and the fill was at least the packet length.
- R7: `host_tx_alarm` is registered. It is 1 in the cycle after a cycle in which DMA mode was set, `cfg_dir`=0 and the free space (DEPTH minus fill) was at least the packet length.
- R8: The packet length resets to 8 longwords. A write through `cfg_pkt_wr` of 0, or of a value above DEPTH, loads DEPTH.
- R9: Halfwords are little-endian. The first of each pair is longword bits 15:0 and the second is bits 31:16. Toward the drive, bits 15:0 are sent before bits 31:16, and longwords keep FIFO order.
- R10: A `cfg_flush` pulse, or a cycle in which `cfg_dir` differs from its value in the previous cycle, empties the store, drops any half-built longword or half-sent longword, and pauses the bus side in that cycle.
- R11: In reset `bus_rst_n`=0, `bus_dmack_n`=1 and `bus_data_oe`=0. From the first cycle after reset `bus_rst_n`=1. `bus_data_oe` is 1 in the cycle after an active host-to-drive transfer cycle.
- R12: A host write while the store is full, a host read while it is empty, and a host access in the wrong direction are dropped without changing the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_mode | input | 1 | 1 = DMA mode, 0 = PIO (store idle) |
| cfg_dma_en | input | 1 | DMA transfer enable bit |
| cfg_udma_sel | input | 1 | 1 = ultra DMA, 0 = multiword DMA |
| cfg_dir | input | 1 | 1 = drive-to-host, 0 = host-to-drive |
| cfg_flush | input | 1 | Empty the store (pulse) |
| cfg_pkt_wr | input | 1 | Load packet length |
| cfg_pkt_len | input | PKT_IN_W | Requested packet length in longwords |
| drv_dmarq | input | 1 | Drive DMA request |
| bus_rx_valid | input | 1 | Engine offers a halfword from the drive |
| bus_rx_half | input | 16 | Halfword from the drive |
| bus_tx_ready | input | 1 | Engine takes a halfword for the drive |
| bus_tx_half | output | 16 | Halfword for the drive |
| bus_pause | output | 1 | Engine must hold off this cycle |
| eng_udma_sel | output | 1 | Registered copy of the DMA flavour bit |
| bus_rst_n | output | 1 | Disk bus reset, active low |
| bus_dmack_n | output | 1 | DMA acknowledge, active low |
| bus_data_oe | output | 1 | Drive the data bus (0 = released) |
| host_wr_en | input | 1 | Host writes a longword |
| host_wr_data | input | 32 | Longword from the host |
| host_rd_en | input | 1 | Host reads a longword |
| host_rd_data | output | 32 | Head longword for the host |
| host_rx_alarm | output | 1 | A full packet is ready to read |
| host_tx_alarm | output | 1 | Room for a full packet |

## Verification
The bench fills the store to exactly 64 longwords and keeps offering halfwords, so a pause computed one entry late would let a write wrap over the oldest data. It drains to empty toward the drive, where a missing underflow guard would send stale halfwords. It loads packet lengths of 0 and above the depth, where a design without clamping would raise the receive alarm at a fill of zero or never. Random traffic mixes direction changes and flushes in the middle of a half-built longword. It also lets host pushes and pops share a cycle with bus-side transfers, which catches swapped halves, fill counts off by one, and alarms that are not delayed by exactly one cycle.

// File: rtl/ata_dfifo_pkg.sv
package ata_dfifo_pkg;

    typedef enum logic {
        DIR_TO_DRIVE = 1'b0,
        DIR_TO_HOST  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [31:0] wdata;
    } fifo_op_t;

    function automatic int unsigned clamp_pkt(int unsigned req, int unsigned depth);
        return (req == 0 || req > depth) ? depth : req;
    endfunction

endpackage

// File: rtl/ata_dfifo_store.sv
module ata_dfifo_store
    import ata_dfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  fifo_op_t      op,
    output logic [31:0]   rdata,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty
);
    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (op.push) mem[wptr] <= op.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (op.push) wptr <= nxt(wptr);
            if (op.pop)  rptr <= nxt(rptr);
            case ({op.push, op.pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !op.push || op.pop);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !op.pop);
endmodule

// File: rtl/ata_dfifo_halves.sv
module ata_dfifo_halves (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        rx_take,
    input  logic [15:0] rx_half,
    output logic        rx_push,
    output logic [31:0] rx_word,
    input  logic        tx_take,
    input  logic [31:0] tx_head,
    output logic [15:0] tx_half,
    output logic        tx_pop
);
    logic [15:0] hold_q;
    logic        hv_q;
    logic        tsel_q;

    assign rx_push = rx_take & hv_q;
    assign rx_word = {rx_half, hold_q};
    assign tx_half = tsel_q ? tx_head[31:16] : tx_head[15:0];
    assign tx_pop  = tx_take & tsel_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold_q <= '0;
            hv_q   <= 1'b0;
            tsel_q <= 1'b0;
        end else begin
            if (rx_take) begin
                hv_q <= ~hv_q;
                if (!hv_q) hold_q <= rx_half;
            end
            if (tx_take) tsel_q <= ~tsel_q;
        end
    end

    // R9
    pair_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hv_q) |-> $past(rx_take));
    // R9
    send_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tsel_q) |-> $past(tx_take) && !$past(tx_pop));
endmodule

// File: rtl/ata_dfifo_alarm.sv
module ata_dfifo_alarm #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_mode,
    input  logic          to_host,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] pkt_len,
    output logic          rx_alarm,
    output logic          tx_alarm
);
    logic [CW-1:0] room;
    assign room = CW'(DEPTH) - fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_alarm <= 1'b0;
            tx_alarm <= 1'b0;
        end else begin
            rx_alarm <= dma_mode &  to_host & (fill >= pkt_len);
            tx_alarm <= dma_mode & !to_host & (room >= pkt_len);
        end
    end

    // R6 R7
    alarm_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_alarm && tx_alarm));
    // R1
    pio_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |=> !rx_alarm && !tx_alarm);
endmodule

// File: rtl/ata_dma_fifo.sv
module ata_dma_fifo
    import ata_dfifo_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int PKT_IN_W  = 8,
    parameter int PKT_RESET = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_dma_mode,
    input  logic                cfg_dma_en,
    input  logic                cfg_udma_sel,
    input  logic                cfg_dir,
    input  logic                cfg_flush,
    input  logic                cfg_pkt_wr,
    input  logic [PKT_IN_W-1:0] cfg_pkt_len,
    input  logic                drv_dmarq,
    input  logic                bus_rx_valid,
    input  logic [15:0]         bus_rx_half,
    input  logic                bus_tx_ready,
    output logic [15:0]         bus_tx_half,
    output logic                bus_pause,
    output logic                eng_udma_sel,
    output logic                bus_rst_n,
    output logic                bus_dmack_n,
    output logic                bus_data_oe,
    input  logic                host_wr_en,
    input  logic [31:0]         host_wr_data,
    input  logic                host_rd_en,
    output logic [31:0]         host_rd_data,
    output logic                host_rx_alarm,
    output logic                host_tx_alarm
);
    xfer_dir_e     dir, dir_q;
    logic [CW-1:0] pkt_q, fill;
    logic          full, empty, act, flush_now, to_host;
    logic          rx_take, tx_take, rx_push, tx_pop, host_push, host_pop;
    logic [31:0]   rx_word, head;
    fifo_op_t      op;

    assign dir       = xfer_dir_e'(cfg_dir);
    assign to_host   = (dir == DIR_TO_HOST);
    assign flush_now = cfg_flush | (dir != dir_q);
    assign act       = cfg_dma_mode & cfg_dma_en & drv_dmarq;
    assign bus_pause = !act | flush_now | (to_host ? full : empty);

    assign rx_take   = bus_rx_valid & !bus_pause &  to_host;
    assign tx_take   = bus_tx_ready & !bus_pause & !to_host;
    assign host_push = cfg_dma_mode & !to_host & host_wr_en & !full  & !flush_now;
    assign host_pop  = cfg_dma_mode &  to_host & host_rd_en & !empty & !flush_now;

    always_comb begin
        op.push  = to_host ? rx_push : host_push;
        op.pop   = to_host ? host_pop : tx_pop;
        op.wdata = to_host ? rx_word : host_wr_data;
    end

    assign host_rd_data = head;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q        <= DIR_TO_DRIVE;
            pkt_q        <= CW'(PKT_RESET);
            eng_udma_sel <= 1'b0;
            bus_rst_n    <= 1'b0;
            bus_dmack_n  <= 1'b1;
            bus_data_oe  <= 1'b0;
        end else begin
            dir_q        <= dir;
            eng_udma_sel <= cfg_udma_sel;
            bus_rst_n    <= 1'b1;
            bus_dmack_n  <= !act;
            bus_data_oe  <= act & !to_host;
            if (cfg_pkt_wr)
                pkt_q <= CW'(clamp_pkt(int'(cfg_pkt_len), DEPTH));
        end
    end

    ata_dfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(flush_now), .op(op),
        .rdata(head), .fill(fill), .full(full), .empty(empty)
    );

    ata_dfifo_halves u_halves (
        .clk(clk), .rst(rst), .clr(flush_now),
        .rx_take(rx_take), .rx_half(bus_rx_half),
        .rx_push(rx_push), .rx_word(rx_word),
        .tx_take(tx_take), .tx_head(head),
        .tx_half(bus_tx_half), .tx_pop(tx_pop)
    );

    ata_dfifo_alarm #(.DEPTH(DEPTH)) u_alarm (
        .clk(clk), .rst(rst), .dma_mode(cfg_dma_mode), .to_host(to_host),
        .fill(fill), .pkt_len(pkt_q),
        .rx_alarm(host_rx_alarm), .tx_alarm(host_tx_alarm)
    );

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rx_valid || bus_tx_ready) && !(cfg_dma_en && drv_dmarq) |-> bus_pause);
    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_now |=> (fill == '0));
    // R11
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> bus_rst_n);
endmodule

// File: tb/tb_ata_dma_fifo.sv
module tb_ata_dma_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dma_mode = 0, cfg_dma_en = 0, cfg_udma_sel = 0, cfg_dir = 0;
    logic        cfg_flush = 0, cfg_pkt_wr = 0, drv_dmarq = 0;
    logic [7:0]  cfg_pkt_len = 0;
    logic        bus_rx_valid = 0, bus_tx_ready = 0, host_wr_en = 0, host_rd_en = 0;
    logic [15:0] bus_rx_half = 0;
    logic [31:0] host_wr_data = 0;
    logic [15:0] bus_tx_half;
    logic        bus_pause, eng_udma_sel, bus_rst_n, bus_dmack_n, bus_data_oe;
    logic [31:0] host_rd_data;
    logic        host_rx_alarm, host_tx_alarm;

    always #5 clk = ~clk;

    ata_dma_fifo dut (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] mq[$];
    logic [15:0] m_hold;
    bit m_hv = 0, m_ts = 0, m_dirq = 0;
    int m_pkt = 8;
    bit m_rxal = 0, m_txal = 0, m_dmack_n = 1, m_udma = 0, m_oe = 0;

    function automatic int clampf(int v);
        return (v == 0 || v > 64) ? 64 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, a, e);
        end
    endtask

    task automatic step();
        bit act, fl, full, empty, ep;
        bit n_rx, n_tx;
        string tag;
        #1;
        act   = cfg_dma_mode & cfg_dma_en & drv_dmarq;
        fl    = cfg_flush | (cfg_dir != m_dirq);
        full  = (mq.size() == 64);
        empty = (mq.size() == 0);
        ep    = !act | fl | (cfg_dir ? full : empty);
        tag = !cfg_dma_mode ? "R1" : !(cfg_dma_en && drv_dmarq) ? "R2" : fl ? "R10" : cfg_dir ? "R4" : "R5";
        chk(bus_pause == ep, tag, 32'(bus_pause), 32'(ep));
        if (!cfg_dir && !empty && !fl) begin
            logic [15:0] eh = m_ts ? mq[0][31:16] : mq[0][15:0];
            chk(bus_tx_half == eh, "R9", 32'(bus_tx_half), 32'(eh));
        end
        if (cfg_dir && !empty)
            chk(host_rd_data == mq[0], "R9", host_rd_data, mq[0]);
        n_rx = cfg_dma_mode & cfg_dir & (mq.size() >= m_pkt);
        n_tx = cfg_dma_mode & !cfg_dir & ((64 - mq.size()) >= m_pkt);
        if (fl) begin
            mq.delete();
            m_hv = 0;
            m_ts = 0;
        end else if (cfg_dir) begin
            if (cfg_dma_mode && host_rd_en && !empty) void'(mq.pop_front());
            if (act && bus_rx_valid && !full) begin
                if (m_hv) begin mq.push_back({bus_rx_half, m_hold}); m_hv = 0; end
                else begin m_hold = bus_rx_half; m_hv = 1; end
            end
        end else begin
            if (act && bus_tx_ready && !empty) begin
                if (m_ts) begin void'(mq.pop_front()); m_ts = 0; end
                else m_ts = 1;
            end
            if (cfg_dma_mode && host_wr_en && !full) mq.push_back(host_wr_data);
        end
        m_dirq = cfg_dir;
        if (cfg_pkt_wr) m_pkt = clampf(int'(cfg_pkt_len));
        m_rxal = n_rx;
        m_txal = n_tx;
        m_dmack_n = !act;
        m_oe = act & !cfg_dir;
        m_udma = cfg_udma_sel;
        @(posedge clk);
        @(negedge clk);
        chk(host_rx_alarm == m_rxal, "R6", 32'(host_rx_alarm), 32'(m_rxal));
        chk(host_tx_alarm == m_txal, "R7", 32'(host_tx_alarm), 32'(m_txal));
        chk(bus_dmack_n == m_dmack_n, "R2", 32'(bus_dmack_n), 32'(m_dmack_n));
        chk(bus_data_oe == m_oe, "R11", 32'(bus_data_oe), 32'(m_oe));
        chk(eng_udma_sel == m_udma, "R3", 32'(eng_udma_sel), 32'(m_udma));
    endtask

    task automatic idle_bus();
        bus_rx_valid = 0; bus_tx_ready = 0; host_wr_en = 0; host_rd_en = 0;
        cfg_flush = 0; cfg_pkt_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a7a));
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(bus_rst_n == 0, "R11", 32'(bus_rst_n), 0);
        chk(bus_dmack_n == 1, "R11", 32'(bus_dmack_n), 1);
        chk(bus_data_oe == 0, "R11", 32'(bus_data_oe), 0);
        rst = 0;
        step();
        chk(bus_rst_n == 1, "R11", 32'(bus_rst_n), 1);

        // R1: PIO mode host writes are dropped
        cfg_dir = 0; host_wr_en = 1; host_wr_data = 32'hdead_beef;
        repeat (3) step();
        idle_bus();
        cfg_dma_mode = 1; cfg_dma_en = 1; drv_dmarq = 1;
        #1 chk(bus_pause == 1, "R1", 32'(bus_pause), 1);
        step();

        // R8 default packet 8 and R9 packing, drive-to-host
        cfg_dir = 1; step();
        for (int i = 0; i < 14; i++) begin
            bus_rx_valid = 1; bus_rx_half = 16'(16'h1000 + i); step();
        end
        idle_bus(); step(); step();
        chk(host_rx_alarm == 0, "R8", 32'(host_rx_alarm), 0);
        bus_rx_valid = 1; bus_rx_half = 16'haaaa; step();
        bus_rx_half = 16'h5555; step();
        idle_bus(); step(); step();
        chk(host_rx_alarm == 1, "R8", 32'(host_rx_alarm), 1);
        #1 chk(host_rd_data == 32'h1001_1000, "R9", host_rd_data, 32'h1001_1000);
        cfg_pkt_wr = 1; cfg_pkt_len = 0; step();
        idle_bus(); step(); step();
        chk(host_rx_alarm == 0, "R8", 32'(host_rx_alarm), 0);
        cfg_pkt_wr = 1; cfg_pkt_len = 100; step();
        idle_bus();
        for (int i = 0; i < 120; i++) begin
            bus_rx_valid = 1; bus_rx_half = 16'($urandom); step();
        end
        #1 chk(bus_pause == 1, "R4", 32'(bus_pause), 1);
        idle_bus(); step();
        chk(host_rx_alarm == 1, "R8", 32'(host_rx_alarm), 1);

        // R10 flush, then R12 overfill from host, host-to-drive
        cfg_flush = 1; step(); idle_bus();
        cfg_dir = 0; step();
        #1 chk(bus_pause == 1, "R10", 32'(bus_pause), 1);
        cfg_pkt_wr = 1; cfg_pkt_len = 8; step(); idle_bus();
        for (int i = 0; i < 65; i++) begin
            host_wr_en = 1; host_wr_data = 32'(32'hc000_0000 + i); step();
        end
        idle_bus(); step();
        chk(host_tx_alarm == 0, "R7", 32'(host_tx_alarm), 0);
        for (int i = 0; i < 128; i++) begin
            bus_tx_ready = 1; step();
        end
        idle_bus();
        #1 chk(bus_pause == 1, "R12", 32'(bus_pause), 1);
        step();

        // random traffic
        cfg_pkt_wr = 1; cfg_pkt_len = 4; step(); idle_bus();
        for (int i = 0; i < 4000; i++) begin
            cfg_dma_mode = ($urandom_range(0, 19) != 0);
            cfg_dma_en   = ($urandom_range(0, 9) != 0);
            drv_dmarq    = ($urandom_range(0, 6) != 0);
            cfg_udma_sel = 1'($urandom);
            if ($urandom_range(0, 99) < 2) cfg_dir = ~cfg_dir;
            cfg_flush    = ($urandom_range(0, 199) == 0);
            cfg_pkt_wr   = ($urandom_range(0, 49) == 0);
            cfg_pkt_len  = 8'($urandom_range(0, 80));
            bus_rx_valid = 1'($urandom);
            bus_rx_half  = 16'($urandom);
            bus_tx_ready = 1'($urandom);
            host_wr_en   = ($urandom_range(0, 2) != 0) ^ (i[9]);
            host_wr_data = $urandom;
            host_rd_en   = ($urandom_range(0, 2) != 0) ^ (i[8]);
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule